// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the digital side of a 12-bit successive-approximation converter. It decides when a conversion may begin, runs the sample window, and then drives a trial code to an external resistor-string DAC. It builds the answer one bit per clock, from the most significant bit down to the least significant, using a one-bit comparator decision that reports whether the held input is at or above the current tap. The sample-and-hold, the resistor string and the comparator are outside the block.

Software controls a start bit, and the block reports that bit on `start_o`. In software-trigger mode a write of 1 sets the bit. In timer-trigger mode a timer pulse sets it. In single mode the bit clears itself when the conversion finishes. In continuous mode the block starts the next sample at once, and keeps doing so until the bit is cleared. Clearing the bit, or dropping the comparator enable, abandons a conversion that is in flight.

A settling counter holds off any start until the comparator has been enabled for a fixed number of cycles. The channel select is only registered and passed on.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `samp_o`, `eoc_o`, `start_o`, `tap_o` and `result_o` are all 0.
- R2: After `cmp_en_i` rises, no conversion begins until it has been high for SETTLE_CYC clock edges. If the start bit is already set, `busy_o` rises on edge SETTLE_CYC+1, counting the first edge that sees the enable as edge 1.
- R3: Each conversion opens with `samp_o` high for exactly SAMPLE_CYC cycles. During that window `tap_o` is 0.
- R4: The first trial tap after sampling has only bit 11 set (0x800).
- R5: Each step sets the next lower bit on top of the bits already decided. It keeps that bit when `cmp_i` is 1 (input at or above tap) and clears it otherwise. With an ideal comparator, the latched result equals the input code.
- R6: `busy_o` stays high for SAMPLE_CYC+12 cycles. The result register loads on the edge where `busy_o` falls, and `eoc_o` is high for exactly that one cycle. Before that, `result_o` does not change.
- R7: With `trig_sel_i`=0, `start_set_i` sets the start bit and `tmr_trig_i` has no effect. With `trig_sel_i`=1, `tmr_trig_i` sets the start bit and `start_set_i` has no effect.
- R8: In single mode (`cont_i`=0), the start bit clears on the `eoc_o` edge and no further conversion follows.
- R9: In continuous mode (`cont_i`=1), the next sample starts on the edge that ends the previous conversion. End-of-conversion pulses are then SAMPLE_CYC+12 cycles apart, and the start bit stays set.
- R10: Asserting `start_clr_i` during a conversion returns the block to idle on the next edge. It clears the start bit, raises no `eoc_o` and leaves `result_o` unchanged.
- R11: Timer triggers that arrive while a conversion is busy are ignored: no extra conversion follows.
- R12: Dropping `cmp_en_i` aborts any conversion and clears the start bit. A later start again waits the full settling delay.
- R13: `chan_o` shows the value `chan_i` had one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_en_i | input | 1 | Comparator enable; rising edge starts the settling wait |
| start_set_i | input | 1 | Software write of 1 to the start bit |
| start_clr_i | input | 1 | Software write of 0 to the start bit |
| trig_sel_i | input | 1 | 0 = software start, 1 = timer start |
| tmr_trig_i | input | 1 | Timer trigger pulse |
| cont_i | input | 1 | 0 = single conversion, 1 = continuous |
| cmp_i | input | 1 | Comparator decision: 1 when held input is at or above tap |
| chan_i | input | CH_W | Channel select |
| chan_o | output | CH_W | Registered channel select |
| start_o | output | 1 | Start bit |
| samp_o | output | 1 | Sample window active (0 = hold) |
| busy_o | output | 1 | Conversion in progress |
| tap_o | output | RES_W | Trial code to the DAC tap selector |
| result_o | output | RES_W | Latched conversion result |
| eoc_o | output | 1 | End-of-conversion pulse |

## Verification
The ideal comparator is run against several kinds of input code:
- The two extremes 0x000 and 0xFFF show that the keep and clear paths both reach every bit.
- The pair 0x800 and 0x7FF sits on either side of the first trial, which tells an at-or-above comparison apart from a strictly-above one.
- The alternating patterns 0xAAA and 0x555, together with 0x001 and 0xFFE, expose a decision written to the wrong bit position or a lowest bit that is never resolved.
- Random codes, plus back-to-back continuous conversions on changing inputs, show that no decided bit carries over from one conversion to the next.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/sar_settle.sv
module sar_settle #(
  parameter int unsigned SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic ready_o
);
  generate
    if (SETTLE_CYC == 0) begin : g_nowait
      always_ff @(posedge clk) begin
        if (rst) ready_o <= 1'b0;
        else     ready_o <= en_i;
      end
    end else begin : g_wait
      localparam int unsigned CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (rst || !en_i) begin
          cnt_q   <= '0;
          ready_o <= 1'b0;
        end else if (!ready_o) begin
          if (cnt_q == CW'(SETTLE_CYC - 1)) ready_o <= 1'b1;
          else                              cnt_q   <= cnt_q + 1'b1;
        end
      end
    end
  endgenerate

  // R12
  settle_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !ready_o);
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_seq_pkg::*;
#(
  parameter int unsigned SAMPLE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cmp_en_i,
  input  logic ready_i,
  input  logic start_set_i,
  input  logic start_clr_i,
  input  logic trig_sel_i,
  input  logic tmr_trig_i,
  input  logic cont_i,
  input  logic done_i,
  output logic go_o,
  output logic busy_o,
  output logic samp_o,
  output logic run_o,
  output logic arm_o,
  output logic kill_o
);
  localparam int unsigned SCW = $clog2(SAMPLE_CYC + 1);

  seq_state_e     st_q;
  logic [SCW-1:0] scnt_q;
  logic           start_req;

  assign busy_o    = (st_q != ST_IDLE);
  assign samp_o    = (st_q == ST_SAMP);
  assign run_o     = (st_q == ST_CONV);
  assign kill_o    = busy_o && (start_clr_i || !cmp_en_i);
  assign arm_o     = samp_o && (scnt_q == SCW'(SAMPLE_CYC - 1));
  assign start_req = trig_sel_i ? tmr_trig_i : start_set_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      scnt_q <= '0;
      go_o   <= 1'b0;
    end else begin
      if (!cmp_en_i || start_clr_i)           go_o <= 1'b0;
      else if (done_i && !cont_i)             go_o <= 1'b0;
      else if (!go_o && !busy_o && start_req) go_o <= 1'b1;

      unique case (st_q)
        ST_IDLE: begin
          if (go_o && ready_i && cmp_en_i && !start_clr_i) begin
            st_q   <= ST_SAMP;
            scnt_q <= '0;
          end
        end
        ST_SAMP: begin
          if (kill_o)     st_q   <= ST_IDLE;
          else if (arm_o) st_q   <= ST_CONV;
          else            scnt_q <= scnt_q + 1'b1;
        end
        ST_CONV: begin
          if (kill_o) st_q <= ST_IDLE;
          else if (done_i) begin
            if (cont_i) begin
              st_q   <= ST_SAMP;
              scnt_q <= '0;
            end else begin
              st_q <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  settle_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(ready_i));

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    kill_o |=> !busy_o && !go_o);

  // R8
  single_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done_i && !cont_i && !kill_o |=> !go_o && !busy_o);
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_i,
  input  logic             run_i,
  input  logic             kill_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] tap_o,
  output logic [RES_W-1:0] result_o,
  output logic             eoc_o,
  output logic             done_o
);
  localparam int unsigned IW = $clog2(RES_W);
  localparam logic [RES_W-1:0] MSB_CODE = {1'b1, {(RES_W-1){1'b0}}};

  logic [IW-1:0]    idx_q;
  logic [RES_W-1:0] decided;
  logic [RES_W-1:0] next_bit;

  for (genvar b = 0; b < RES_W; b++) begin : g_bit
    assign decided[b] = (idx_q == IW'(b)) ? cmp_i : tap_o[b];
    if (b == RES_W - 1) begin : g_top
      assign next_bit[b] = 1'b0;
    end else begin : g_low
      assign next_bit[b] = (idx_q == IW'(b + 1));
    end
  end

  assign done_o = run_i && (idx_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_o    <= '0;
      idx_q    <= '0;
      result_o <= '0;
      eoc_o    <= 1'b0;
    end else begin
      eoc_o <= 1'b0;
      if (kill_i) begin
        tap_o <= '0;
      end else if (arm_i) begin
        tap_o <= MSB_CODE;
        idx_q <= IW'(RES_W - 1);
      end else if (run_i) begin
        if (idx_q == '0) begin
          result_o <= decided;
          eoc_o    <= 1'b1;
          tap_o    <= '0;
        end else begin
          tap_o <= decided | next_bit;
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end

  // R4
  first_tap_chk: assert property (@(posedge clk) disable iff (rst)
    arm_i && !kill_i |=> tap_o == MSB_CODE);

  // R6
  eoc_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    eoc_o |=> !eoc_o);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(result_o) |-> eoc_o);
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int unsigned RES_W      = 12,
  parameter int unsigned SAMPLE_CYC = 4,
  parameter int unsigned SETTLE_CYC = 16,
  parameter int unsigned CH_W       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_en_i,
  input  logic             start_set_i,
  input  logic             start_clr_i,
  input  logic             trig_sel_i,
  input  logic             tmr_trig_i,
  input  logic             cont_i,
  input  logic             cmp_i,
  input  logic [CH_W-1:0]  chan_i,
  output logic [CH_W-1:0]  chan_o,
  output logic             start_o,
  output logic             samp_o,
  output logic             busy_o,
  output logic [RES_W-1:0] tap_o,
  output logic [RES_W-1:0] result_o,
  output logic             eoc_o
);
  logic ready, run, arm, kill, done;

  sar_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .en_i(cmp_en_i), .ready_o(ready)
  );

  sar_ctrl #(.SAMPLE_CYC(SAMPLE_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .cmp_en_i(cmp_en_i), .ready_i(ready),
    .start_set_i(start_set_i), .start_clr_i(start_clr_i),
    .trig_sel_i(trig_sel_i), .tmr_trig_i(tmr_trig_i), .cont_i(cont_i),
    .done_i(done), .go_o(start_o), .busy_o(busy_o), .samp_o(samp_o),
    .run_o(run), .arm_o(arm), .kill_o(kill)
  );

  sar_engine #(.RES_W(RES_W)) u_engine (
    .clk(clk), .rst(rst), .arm_i(arm), .run_i(run), .kill_i(kill),
    .cmp_i(cmp_i), .tap_o(tap_o), .result_o(result_o), .eoc_o(eoc_o),
    .done_o(done)
  );

  always_ff @(posedge clk) begin
    if (rst) chan_o <= '0;
    else     chan_o <= chan_i;
  end

  // R3
  sample_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    samp_o |-> tap_o == '0);
endmodule

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RES_W  = 12;
  localparam int SAMP   = 4;
  localparam int SETTLE = 16;
  localparam int CH_W   = 3;
  localparam int NVEC   = 10;
  localparam logic [RES_W-1:0] VEC [NVEC] = '{
    12'h000, 12'hFFF, 12'h800, 12'h7FF, 12'h001,
    12'hAAA, 12'h555, 12'hFFE, 12'h123, 12'h400};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_en = 0, start_set = 0, start_clr = 0, trig_sel = 0, tmr_trig = 0, cont = 0;
  logic [CH_W-1:0]  chan_i = '0;
  logic [CH_W-1:0]  chan_o;
  logic start_o, samp, busy, eoc, cmp;
  logic [RES_W-1:0] tap, result;
  logic [RES_W-1:0] vin = '0;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign cmp = (vin >= tap);

  sar_seq #(.RES_W(RES_W), .SAMPLE_CYC(SAMP), .SETTLE_CYC(SETTLE), .CH_W(CH_W)) u_sar_seq (
    .clk(clk), .rst(rst), .cmp_en_i(cmp_en), .start_set_i(start_set),
    .start_clr_i(start_clr), .trig_sel_i(trig_sel), .tmr_trig_i(tmr_trig),
    .cont_i(cont), .cmp_i(cmp), .chan_i(chan_i), .chan_o(chan_o),
    .start_o(start_o), .samp_o(samp), .busy_o(busy), .tap_o(tap),
    .result_o(result), .eoc_o(eoc)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // Waits for one conversion end; optional timer pulse at cycle trig_at.
  task automatic measure(input int trig_at, output int busy_n, output int samp_n,
                         output int eoc_n, output int tap0, output int cyc, output int sq_bad);
    busy_n = 0; samp_n = 0; eoc_n = 0; tap0 = 0; cyc = 0; sq_bad = 0;
    while (eoc_n == 0 && cyc < 400) begin
      @(negedge clk);
      cyc++;
      tmr_trig = 1'b0;
      if (trig_at != 0 && cyc == trig_at) tmr_trig = 1'b1;
      if (busy) busy_n++;
      if (samp) samp_n++;
      if (samp && tap != 0) sq_bad++;
      if (eoc) eoc_n++;
      if (tap != 0 && tap0 == 0) tap0 = int'(tap);
    end
    @(negedge clk);
    tmr_trig = 1'b0;
  endtask

  task automatic run_single(input logic [RES_W-1:0] v);
    int bn, sn, en, t0, cy, sq;
    @(negedge clk);
    vin = v; start_set = 1'b1;
    @(negedge clk);
    start_set = 1'b0;
    check_eq("R7 start set by software", int'(start_o), 1);
    measure(0, bn, sn, en, t0, cy, sq);
    check_eq("R6 busy length", bn, SAMP + 12);
    check_eq("R3 sample length", sn, SAMP);
    check_eq("R3 tap zero while sampling", sq, 0);
    check_eq("R4 first tap", t0, 12'h800);
    check_eq("R5 result equals input", int'(result), int'(v));
    check_eq("R6 eoc latency", cy, SAMP + 13);
    check_eq("R6 eoc single pulse", int'(eoc), 0);
    check_eq("R8 start cleared in single", int'(start_o), 0);
    check_eq("R8 idle after single", int'(busy), 0);
  endtask

  // Raise enable with a pending start; return edge count until busy rises.
  task automatic settle_start(input string req);
    int k;
    @(negedge clk);
    cmp_en = 1'b1; start_set = 1'b1;
    k = 0;
    do begin
      @(negedge clk);
      start_set = 1'b0;
      k++;
    end while (!busy && k < 200);
    check_eq(req, k, SETTLE + 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int bn, sn, en, t0, cy, sq, n;
    logic [RES_W-1:0] saved, v;
    // R1 reset state
    repeat (3) @(negedge clk);
    check_eq("R1 busy in reset", int'(busy), 0);
    check_eq("R1 eoc in reset", int'(eoc), 0);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R1 busy", int'(busy), 0);
    check_eq("R1 samp", int'(samp), 0);
    check_eq("R1 eoc", int'(eoc), 0);
    check_eq("R1 start", int'(start_o), 0);
    check_eq("R1 tap", int'(tap), 0);
    check_eq("R1 result", int'(result), 0);

    // R13 channel passthrough
    chan_i = 3'd5;
    @(negedge clk);
    check_eq("R13 channel registered", int'(chan_o), 5);

    // R2 settling wait
    vin = 12'h9C3;
    settle_start("R2 settle delay");
    measure(0, bn, sn, en, t0, cy, sq);
    check_eq("R2 result after settle", int'(result), 12'h9C3);

    // Table walk: R3 R4 R5 R6 R8
    for (int i = 0; i < NVEC; i++) run_single(VEC[i]);
    for (int i = 0; i < 20; i++) run_single(RES_W'($urandom));

    // R7 software mode ignores timer
    @(negedge clk); tmr_trig = 1'b1;
    @(negedge clk); tmr_trig = 1'b0;
    check_eq("R7 timer ignored in software mode", int'(start_o), 0);
    repeat (4) @(negedge clk);
    check_eq("R7 no conversion from timer in software mode", int'(busy), 0);

    // R7 timer mode ignores software set
    trig_sel = 1'b1;
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
    check_eq("R7 software set ignored in timer mode", int'(start_o), 0);
    repeat (4) @(negedge clk);
    check_eq("R7 no conversion from software in timer mode", int'(busy), 0);

    // R7 timer start, R11 trigger while busy ignored
    vin = 12'h3E7;
    @(negedge clk); tmr_trig = 1'b1;
    @(negedge clk); tmr_trig = 1'b0;
    check_eq("R7 timer sets start", int'(start_o), 1);
    measure(SAMP + 3, bn, sn, en, t0, cy, sq);
    check_eq("R7 timer conversion result", int'(result), 12'h3E7);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (busy || eoc) n++;
    end
    check_eq("R11 busy trigger ignored", n, 0);
    trig_sel = 1'b0;

    // R9 continuous mode
    cont = 1'b1; vin = 12'h0F0;
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
    measure(0, bn, sn, en, t0, cy, sq);
    check_eq("R9 first continuous result", int'(result), 12'h0F0);
    check_eq("R9 busy stays high", int'(busy), 1);
    vin = 12'hE0D;
    n = 1;
    while (!eoc && n < 200) begin @(negedge clk); n++; end
    check_eq("R9 eoc spacing", n, SAMP + 12);
    check_eq("R9 second result", int'(result), 12'hE0D);
    check_eq("R9 start kept", int'(start_o), 1);

    // R10 abort mid-conversion
    saved = result;
    vin = 12'h111;
    repeat (SAMP + 3) @(negedge clk);
    check_eq("R10 busy before abort", int'(busy), 1);
    start_clr = 1'b1;
    @(negedge clk); start_clr = 1'b0;
    check_eq("R10 idle after abort", int'(busy), 0);
    check_eq("R10 start cleared", int'(start_o), 0);
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (eoc || busy) n++;
    end
    check_eq("R10 no eoc after abort", n, 0);
    check_eq("R10 result kept", int'(result), int'(saved));
    cont = 1'b0;

    // R12 comparator disable aborts, settle restarts
    v = 12'h6A5; vin = v;
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
    repeat (SAMP + 5) @(negedge clk);
    cmp_en = 1'b0;
    @(negedge clk);
    check_eq("R12 idle after disable", int'(busy), 0);
    check_eq("R12 start cleared", int'(start_o), 0);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (eoc) n++;
    end
    check_eq("R12 no eoc after disable", n, 0);
    settle_start("R12 settle restarts");
    measure(0, bn, sn, en, t0, cy, sq);
    check_eq("R12 result after re-enable", int'(result), int'(v));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule